// File: doc/BRIEF.md
# Wake-up and On-Off Keying Controller for a Low-Frequency Antenna Driver

This block is the digital control state machine of a low-frequency antenna transmitter. It watches a single active-low, bidirectional serial line driven by a host controller. A falling edge on that line wakes the block from a low-power standby state into transmit mode. While it transmits, the line level keys the antenna driver on and off. A low level enables the square-wave carrier. A high level stops the driver and holds its output at ground, which gives full-depth amplitude keying.

Each line transition passes through a debounce filter before the driver reacts. Turn-on waits for a low run counted in ticks of a fixed time base. Turn-off waits for a high run counted in ticks from the antenna oscillator, so it scales with the carrier frequency. Two idle timeouts end a session:
- A line held low too long, counted in fixed time, returns the block straight to standby.
- A line held high too long, counted in carrier cycles, first makes the block pull the line low as a response and then returns it to standby.

The response is short when no fault is flagged and longer when one is.

Top module: `lf_wake_ctrl`

## Requirements
- R1: After reset the block is in standby: `tx_mode`=0, `drv_en`=0, `drv_gnd`=1, `dio_pull`=0.
- R2: In standby, a high-to-low transition of the synchronised line puts the block into transmit mode (`tx_mode`=1). A line that is already low when reset ends also counts as such a transition, because the previous level resets to high.
- R3: `drv_gnd` is always the complement of `drv_en`. `drv_en` can be 1 only in transmit mode.
- R4: In transmit mode, `drv_en` rises only after the synchronised line has stayed low for `ON_DLY` fixed ticks without a break. Shorter low pulses leave the driver off.
- R5: In transmit mode, `drv_en` falls only after the synchronised line has stayed high for `OFF_DLY` carrier ticks. Shorter high glitches leave the driver on, and the delay scales with the carrier tick period.
- R6: When the line stays low for `LOW_TO` fixed ticks in transmit mode, the block returns to standby with the driver off.
- R7: When the line stays high for `HIGH_TO` carrier ticks in transmit mode, the block enters a response phase and asserts `dio_pull` (1 = pull line low).
- R8: The response lasts `ACK_LEN` fixed ticks if `fault` was 0 at the entry cycle, or `ERR_LEN` fixed ticks if it was 1. The block then returns to standby.
- R9: During the response, the driver is off and the line level is ignored. The block's own pull-low does not cause a wake-up after the response ends.
- R10: Every level change of the synchronised line clears the counter that was running for the previous level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dio_in | input | 1 | Raw level of the serial line (wired-AND with the host) |
| tick_fix | input | 1 | One-cycle pulse from the fixed time base |
| tick_car | input | 1 | One-cycle pulse per antenna carrier period |
| fault | input | 1 | Selects the longer error response when high |
| drv_en | output | 1 | Enable for the carrier half-bridge |
| drv_gnd | output | 1 | Hold the driver output at ground |
| tx_mode | output | 1 | High in transmit mode |
| dio_pull | output | 1 | Open-drain pull-low of the serial line |

## Verification
The bench targets several timing corner cases:
- Low pulses just shorter than the on-delay, and high glitches just shorter than the off-delay. A filter that does not restart on every level change would turn the driver on or off early.
- A change of carrier tick period partway through the run. A design that timed the off-delay in fixed ticks would drop the driver at the wrong time.
- The end of each response. If the block's own pull-low were not ignored, it would show up as a fresh wake-up.
- Both response lengths. If the fault input were sampled late, the response would have the wrong length.

// File: rtl/lfw_pkg.sv
package lfw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_TX   = 2'd1,
      ST_RESP = 2'd2
   } lfw_state_e;
endpackage

// File: rtl/lfw_sync.sv
module lfw_sync #(
   parameter int  STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lfw_run_cnt.sv
module lfw_run_cnt #(
   parameter int MAX = 8,
   parameter int W   = $clog2(MAX + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] LIMIT = W'(MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (clr)                   cnt <= '0;
      else if (inc && (cnt != LIMIT)) cnt <= cnt + 1'b1;
   end

   // R10: a clear always leaves the counter at zero on the next cycle
   p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == LIMIT) |=> (cnt == LIMIT) || (cnt == '0));
endmodule

// File: rtl/lfw_fsm.sv
module lfw_fsm
   import lfw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic dio_s,
   input  logic fault,
   input  logic low_on,
   input  logic low_to,
   input  logic high_off,
   input  logic high_to,
   input  logic resp_done,
   output logic in_tx,
   output logic in_resp,
   output logic flt_q,
   output logic drv_en
);
   lfw_state_e st, st_n;
   logic       dio_prev;
   logic       drv_on;
   logic       fall;

   assign fall = dio_prev & ~dio_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dio_prev <= 1'b1;
      else        dio_prev <= dio_s;
   end

   always_comb begin
      st_n = st;
      unique case (st)
         ST_IDLE: if (fall) st_n = ST_TX;
         ST_TX: begin
            if (low_to)       st_n = ST_IDLE;
            else if (high_to) st_n = ST_RESP;
         end
         ST_RESP: if (resp_done) st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         flt_q <= 1'b0;
      end else begin
         st <= st_n;
         if (st == ST_TX && !low_to && high_to) flt_q <= fault;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          drv_on <= 1'b0;
      else if (st != ST_TX) drv_on <= 1'b0;
      else if (low_on)      drv_on <= 1'b1;
      else if (high_off)    drv_on <= 1'b0;
   end

   assign in_tx   = (st == ST_TX);
   assign in_resp = (st == ST_RESP);
   assign drv_en  = drv_on & in_tx;

   // R2: a falling edge in standby starts transmit mode
   p_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && fall) |=> in_tx);
   // R4: the driver only turns on after the low filter expired
   p_on_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en) |-> $past(low_on));
   // R5: the driver turns off once the high filter expired
   p_off_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_tx && drv_en && high_off && !low_to && !high_to) |=> !drv_en);
   // R6: low timeout returns to standby with the driver off
   p_low_to_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_tx && low_to) |=> (st == ST_IDLE && !drv_en));
   // R7: high timeout enters the response phase
   p_high_to_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_tx && !low_to && high_to) |=> in_resp);
   // R9: the response phase never leads straight back to transmit
   p_resp_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_resp |=> !in_tx);
endmodule

// File: rtl/lf_wake_ctrl.sv
module lf_wake_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter int ON_DLY      = 64,
   parameter int LOW_TO      = 4000,
   parameter int OFF_DLY     = 8,
   parameter int HIGH_TO     = 2000,
   parameter int ACK_LEN     = 100,
   parameter int ERR_LEN     = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dio_in,
   input  logic tick_fix,
   input  logic tick_car,
   input  logic fault,
   output logic drv_en,
   output logic drv_gnd,
   output logic tx_mode,
   output logic dio_pull
);
   localparam int LW = $clog2(LOW_TO + 1);
   localparam int HW = $clog2(HIGH_TO + 1);
   localparam int AW = $clog2(ERR_LEN + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ON_DLY < 1 || ON_DLY >= LOW_TO) begin : g_bad_low
         $error("ON_DLY must be in 1..LOW_TO-1");
      end
      if (OFF_DLY < 1 || OFF_DLY >= HIGH_TO) begin : g_bad_high
         $error("OFF_DLY must be in 1..HIGH_TO-1");
      end
      if (ACK_LEN < 1 || ACK_LEN >= ERR_LEN) begin : g_bad_resp
         $error("ACK_LEN must be in 1..ERR_LEN-1");
      end
   endgenerate

   logic          dio_s;
   logic          in_tx, in_resp, flt_q;
   logic [LW-1:0] low_cnt;
   logic [HW-1:0] high_cnt;
   logic [AW-1:0] resp_cnt;
   logic          low_on, low_to, high_off, high_to, resp_done;

   lfw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(dio_in), .q(dio_s));

   lfw_run_cnt #(.MAX(LOW_TO), .W(LW)) u_low (
      .clk(clk), .rst_n(rst_n), .clr(~in_tx | dio_s), .inc(tick_fix), .cnt(low_cnt));

   lfw_run_cnt #(.MAX(HIGH_TO), .W(HW)) u_high (
      .clk(clk), .rst_n(rst_n), .clr(~in_tx | ~dio_s), .inc(tick_car), .cnt(high_cnt));

   lfw_run_cnt #(.MAX(ERR_LEN), .W(AW)) u_resp (
      .clk(clk), .rst_n(rst_n), .clr(~in_resp), .inc(tick_fix), .cnt(resp_cnt));

   assign low_on    = (low_cnt  >= LW'(ON_DLY));
   assign low_to    = (low_cnt  >= LW'(LOW_TO));
   assign high_off  = (high_cnt >= HW'(OFF_DLY));
   assign high_to   = (high_cnt >= HW'(HIGH_TO));
   assign resp_done = flt_q ? (resp_cnt >= AW'(ERR_LEN)) : (resp_cnt >= AW'(ACK_LEN));

   lfw_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .dio_s(dio_s), .fault(fault),
      .low_on(low_on), .low_to(low_to), .high_off(high_off), .high_to(high_to),
      .resp_done(resp_done), .in_tx(in_tx), .in_resp(in_resp), .flt_q(flt_q),
      .drv_en(drv_en));

   assign drv_gnd  = ~drv_en;
   assign tx_mode  = in_tx;
   assign dio_pull = in_resp;

   // R9: no carrier while the block pulls the line
   p_resp_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dio_pull |-> !drv_en);
   // R8: the response ends only after the selected length
   p_resp_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dio_pull) |-> $past(resp_cnt) >= AW'(ACK_LEN));
endmodule

// File: tb/tb_lf_wake_ctrl.sv
module tb_lf_wake_ctrl;
   localparam int ON_DLY = 6, LOW_TO = 40, OFF_DLY = 3, HIGH_TO = 20;
   localparam int ACK_LEN = 5, ERR_LEN = 12;

   logic clk = 0, rst_n = 0;
   logic host = 1, tick_fix = 0, tick_car = 0, fault = 0;
   logic drv_en, drv_gnd, tx_mode, dio_pull, dio_in;
   int   tests = 0, fails = 0;
   int   fix_per = 2, car_per = 3, fix_ph = 0, car_ph = 0;
   int   cyc = 0;

   always #2.5 clk = ~clk;
   assign dio_in = host & ~dio_pull;

   lf_wake_ctrl #(.SYNC_STAGES(2), .ON_DLY(ON_DLY), .LOW_TO(LOW_TO), .OFF_DLY(OFF_DLY),
      .HIGH_TO(HIGH_TO), .ACK_LEN(ACK_LEN), .ERR_LEN(ERR_LEN)) dut (
      .clk(clk), .rst_n(rst_n), .dio_in(dio_in), .tick_fix(tick_fix), .tick_car(tick_car),
      .fault(fault), .drv_en(drv_en), .drv_gnd(drv_gnd), .tx_mode(tx_mode), .dio_pull(dio_pull));

   task automatic chk(input logic act, input logic exp, input string tag);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at cycle %0d: got %0b expected %0b", tag, cyc, act, exp);
      end
   endtask

   // tick generators, driven away from the active edge
   always @(negedge clk) begin
      cyc++;
      fix_ph   = (fix_ph + 1) % fix_per;
      car_ph   = (car_ph + 1) % car_per;
      tick_fix <= (fix_ph == 0);
      tick_car <= (car_ph == 0);
   end

   // behavioural reference model: 0 standby, 1 transmit, 2 response
   int m_s1 = 1, m_s2 = 1, m_prev = 1, m_mode = 0;
   int m_low = 0, m_high = 0, m_resp = 0, m_on = 0, m_flt = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 1; m_s2 = 1; m_prev = 1; m_mode = 0;
         m_low = 0; m_high = 0; m_resp = 0; m_on = 0; m_flt = 0;
      end else begin
         int line, nmode, nlow, nhigh, nresp, non, lvl;
         line = (host && m_mode != 2) ? 1 : 0;
         lvl = m_s2;
         nmode = m_mode; non = m_on;
         nlow  = (m_mode != 1 || lvl == 1) ? 0 : ((tick_fix && m_low < LOW_TO) ? m_low + 1 : m_low);
         nhigh = (m_mode != 1 || lvl == 0) ? 0 : ((tick_car && m_high < HIGH_TO) ? m_high + 1 : m_high);
         nresp = (m_mode != 2) ? 0 : ((tick_fix && m_resp < ERR_LEN) ? m_resp + 1 : m_resp);
         if (m_mode == 0 && lvl == 0 && m_prev == 1) nmode = 1;
         else if (m_mode == 1 && m_low >= LOW_TO) nmode = 0;
         else if (m_mode == 1 && m_high >= HIGH_TO) begin nmode = 2; m_flt = fault; end
         else if (m_mode == 2 && m_resp >= (m_flt ? ERR_LEN : ACK_LEN)) nmode = 0;
         if (m_mode != 1) non = 0;
         else if (m_low >= ON_DLY) non = 1;
         else if (m_high >= OFF_DLY) non = 0;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = line;
         m_mode = nmode; m_low = nlow; m_high = nhigh; m_resp = nresp; m_on = non;
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         logic e_en;
         e_en = (m_on == 1 && m_mode == 1);
         chk(drv_en, e_en, "R3 drv_en vs model");
         chk(drv_gnd, ~e_en, "R3 drv_gnd vs model");
         chk(tx_mode, m_mode == 1, "R2 tx_mode vs model");
         chk(dio_pull, m_mode == 2, "R7 dio_pull vs model");
      end
   end

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic measure_resp(input int lo, input int hi, input string tag);
      int n = 0, guard = 0;
      while (!dio_pull && guard < 400) begin @(negedge clk); guard++; end
      chk(dio_pull, 1'b1, tag);
      while (dio_pull && guard < 400) begin
         @(posedge clk); if (tick_fix) n++;
         @(negedge clk); guard++;
      end
      tests++;
      if (n < lo || n > hi) begin
         fails++;
         $display("FAIL %s: response ticks %0d expected %0d..%0d", tag, n, lo, hi);
      end
   endtask

   initial begin
      wait_n(3);
      chk(tx_mode, 1'b0, "R1 reset tx_mode");
      chk(drv_en, 1'b0, "R1 reset drv_en");
      chk(drv_gnd, 1'b1, "R1 reset drv_gnd");
      chk(dio_pull, 1'b0, "R1 reset dio_pull");
      rst_n = 1;
      wait_n(10);
      chk(tx_mode, 1'b0, "R1 standby with high line");
      // wake with a one-cycle low pulse
      host = 0; wait_n(1); host = 1; wait_n(5);
      chk(tx_mode, 1'b1, "R2 wake on falling edge");
      // short low pulses separated by short highs: driver stays off
      for (int k = 0; k < 5; k++) begin host = 0; wait_n(4); host = 1; wait_n(4); end
      chk(drv_en, 1'b0, "R4 short lows leave driver off (R10 restart)");
      host = 0; wait_n(20);
      chk(drv_en, 1'b1, "R4 driver on after sustained low");
      host = 1; wait_n(5); host = 0; wait_n(3);
      chk(drv_en, 1'b1, "R5 short high glitch suppressed");
      wait_n(8);
      host = 1; wait_n(30);
      chk(drv_en, 1'b0, "R5 driver off after high run");
      chk(tx_mode, 1'b1, "R5 still transmitting");
      // carrier slows down: off-delay must stretch with it
      car_per = 6;
      host = 0; wait_n(20);
      host = 1; wait_n(12);
      chk(drv_en, 1'b1, "R5 off-delay tracks carrier period");
      wait_n(14);
      chk(drv_en, 1'b0, "R5 off after slow carrier ticks");
      car_per = 3;
      host = 0; wait_n(100);
      chk(tx_mode, 1'b0, "R6 low timeout back to standby");
      chk(drv_en, 1'b0, "R6 driver off after timeout");
      wait_n(10);
      chk(tx_mode, 1'b0, "R6 stays in standby while still low");
      host = 1; wait_n(6);
      host = 0; wait_n(2); host = 1; wait_n(4);
      chk(tx_mode, 1'b1, "R2 wake again");
      fault = 0;
      measure_resp(ACK_LEN, ACK_LEN + 1, "R7 R8 acknowledge length");
      wait_n(20);
      chk(tx_mode, 1'b0, "R9 no wake from own pull-low");
      host = 0; wait_n(2); host = 1; wait_n(4);
      fault = 1;
      measure_resp(ERR_LEN, ERR_LEN + 1, "R8 error length");
      fault = 0;
      wait_n(20);
      chk(tx_mode, 1'b0, "R9 standby after error response");
      // host pulses low inside the response: ignored
      host = 0; wait_n(2); host = 1; wait_n(70);
      chk(dio_pull, 1'b1, "R7 response started");
      chk(drv_en, 1'b0, "R9 driver off in response");
      host = 0; wait_n(3); host = 1; wait_n(30);
      chk(tx_mode, 1'b0, "R9 line ignored during response");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #200000;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule